// File: doc/BRIEF.md
# Flash Read Path with Status Polling

This block produces the byte the flash device puts on its data bus during a read cycle. It samples the active-low chip-enable and output-enable controls on the system clock. When both are low, it drives a registered byte and raises an enable that the pad logic uses for tristating. In normal mode the byte is the array word supplied by the storage block. In product-ID mode two fixed identification codes appear at the lowest two addresses.

While a program or chip-erase cycle is running inside the device, the byte carries status in place of array contents. Bit 7 holds the complement of the value the cycle will leave behind. For a page program that is bit 7 of the last byte loaded. For a chip erase it is the erased value FFh, so the bit reads 0. Bit 6 flips once for each separate read cycle and stays still once the cycle is over. Bits 5 to 0 pass the array word through. Host software can therefore wait for completion either by polling bit 7 or by reading bit 6 twice and comparing.

Top module: `flash_rd_path`

## Requirements
- R1: One clock after an edge at which ce_n and oe_n are both sampled low, dq_oe is 1; after any other edge dq_oe is 0. Whenever dq_oe is 0, dq_out is 00h.
- R2: With no busy flag and id_sel low, a read returns array_q as sampled at the preceding clock edge.
- R3: With prog_busy high and erase_busy low, bit 7 of a read returns the inverse of bit 7 of last_byte.
- R4: While either busy flag is high, bit 6 takes a new value at the start of each read cycle. A read cycle starts when the read strobe is sampled active after being sampled inactive. Bit 6 alternates between successive reads, and the first busy read after reset returns 1.
- R5: Within one continuous read cycle, bit 6 keeps the same value on every clock while a busy flag stays high.
- R6: With both busy flags low, bit 6 does not change from one read to the next; it reads array data, and the internal toggle state holds its last value.
- R7: With erase_busy high, bit 7 reads 0 whatever the value of last_byte, and erase_busy takes priority over prog_busy.
- R8: With id_sel high and no busy flag, address 0 reads DAh, address 1 reads C1h, and every other address reads 00h.
- R9: A busy flag takes priority over id_sel, so status is returned in ID mode too.
- R10: While busy, bits 5 to 0 of a read return bits 5 to 0 of array_q.
- R11: After reset, dq_oe is 0 and dq_out is 00h until a read is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Read address |
| array_q | input | 8 | Array word at addr |
| id_sel | input | 1 | Product-ID mode from the command decoder |
| prog_busy | input | 1 | Page program in progress |
| erase_busy | input | 1 | Chip erase in progress |
| last_byte | input | 8 | Last byte loaded into the page buffer |
| dq_out | output | 8 | Byte to drive on the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The assertions assume that addr, array_q, id_sel, the busy flags and last_byte are settled before the clock edge that samples a read, and that the controls change only between edges. The bench changes every input on the falling clock edge and keeps each one constant through a whole read cycle. It also returns the strobe to inactive for at least one clock between reads, so every read is a separate cycle for the toggle bit.

// File: rtl/flash_rd_path.sv
module flash_rd_path #(
  parameter int AW = 17,
  parameter logic [7:0] MFR_CODE = 8'hDA,
  parameter logic [7:0] DEV_CODE = 8'hC1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    array_q,
  input  logic          id_sel,
  input  logic          prog_busy,
  input  logic          erase_busy,
  input  logic [7:0]    last_byte,
  output logic [7:0]    dq_out,
  output logic          dq_oe
);

  logic rd, rd_q, busy, tgl, tgl_nxt, poll_bit;
  logic [7:0] id_byte, byte_nxt;

  assign rd       = ~ce_n & ~oe_n;
  assign busy     = prog_busy | erase_busy;
  assign tgl_nxt  = (rd & ~rd_q & busy) ? ~tgl : tgl;
  assign poll_bit = erase_busy ? 1'b0 : ~last_byte[7];
  assign id_byte  = (addr == '0)      ? MFR_CODE :
                    (addr == AW'(1))  ? DEV_CODE : 8'h00;

  always_comb begin
    if (!rd)         byte_nxt = 8'h00;
    else if (busy)   byte_nxt = {poll_bit, tgl_nxt, array_q[5:0]};
    else if (id_sel) byte_nxt = id_byte;
    else             byte_nxt = array_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      tgl    <= 1'b0;
      dq_oe  <= 1'b0;
      dq_out <= 8'h00;
    end else begin
      rd_q   <= rd;
      tgl    <= tgl_nxt;
      dq_oe  <= rd;
      dq_out <= byte_nxt;
    end
  end

  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == 8'h00);

  assert_prog_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && prog_busy && !erase_busy) |=> dq_out[7] == ~$past(last_byte[7]));

  assert_toggle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && rd_q && busy && dq_oe) |=> dq_out[6] == $past(dq_out[6]));

  assert_erase_poll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && erase_busy) |=> !dq_out[7]);

  assert_id_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && id_sel && !busy && addr == '0) |=> dq_out == MFR_CODE);

  assert_stat_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && busy) |=> dq_out[5:0] == $past(array_q[5:0]));

endmodule

// File: tb/tb_flash_rd_path.sv
module tb_flash_rd_path;
  localparam int AW = 17;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] array_q = 8'h00, last_byte = 8'h00;
  logic id_sel = 1'b0, prog_busy = 1'b0, erase_busy = 1'b0;
  logic [7:0] dq_out;
  logic dq_oe;

  int checks = 0, fails = 0;
  logic tgl_m = 1'b0;
  logic [7:0] prev_b6 = 8'h00;
  bit done = 0;

  flash_rd_path #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
    .array_q(array_q), .id_sel(id_sel), .prog_busy(prog_busy),
    .erase_busy(erase_busy), .last_byte(last_byte), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] exp_byte(logic pb, logic eb, logic ids,
      logic [AW-1:0] a, logic [7:0] arr, logic [7:0] lb, logic t);
    if (eb) return {1'b0, t, arr[5:0]};
    if (pb) return {~lb[7], t, arr[5:0]};
    if (ids) return (a == 0) ? 8'hDA : (a == 1) ? 8'hC1 : 8'h00;
    return arr;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(string req, int n, bit use_oe);
    logic [7:0] e;
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    if (prog_busy || erase_busy) tgl_m = ~tgl_m;
    e = exp_byte(prog_busy, erase_busy, id_sel, addr, array_q, last_byte, tgl_m);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check({req, " R1 oe"}, {7'd0, dq_oe}, 8'h01);
      check(req, dq_out, e);
    end
    if (use_oe) oe_n = 1'b1; else ce_n = 1'b1;
    @(negedge clk);
    check("R1 idle oe", {7'd0, dq_oe}, 8'h00);
    check("R1 idle data", dq_out, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [7:0] b6a;
    seed = $urandom(32'h5EED_0042);
    repeat (2) @(negedge clk);
    check("R11 reset data", dq_out, 8'h00);
    check("R11 reset oe", {7'd0, dq_oe}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after release", dq_out, 8'h00);
    ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    check("R1 ce only", {7'd0, dq_oe}, 8'h00);
    ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    check("R1 oe only", {7'd0, dq_oe}, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1;

    array_q = 8'h5A; addr = 17'h00123;
    do_read("R2 normal", 2, 1'b0);

    prog_busy = 1'b1; last_byte = 8'h3C; array_q = 8'h95;
    do_read("R4 first busy read R3 R10", 3, 1'b1);
    check("R4 first toggle", {7'd0, tgl_m}, 8'h01);
    do_read("R4 second busy read R5", 3, 1'b0);
    last_byte = 8'hC3;
    do_read("R3 poll bit7 high data", 1, 1'b1);

    erase_busy = 1'b1; last_byte = 8'h00;
    do_read("R7 erase over prog", 2, 1'b0);
    prog_busy = 1'b0;
    do_read("R7 erase only", 1, 1'b1);

    erase_busy = 1'b0; array_q = 8'hFF;
    b6a = 8'h00;
    do_read("R6 done read", 1, 1'b0);
    do_read("R6 done read again", 1, 1'b1);
    array_q = 8'hBF;
    do_read("R6 true bit6 clear", 1, 1'b0);

    id_sel = 1'b1; addr = '0;
    do_read("R8 maker code", 2, 1'b0);
    addr = 17'd1;
    do_read("R8 device code", 1, 1'b1);
    addr = 17'd2;
    do_read("R8 other address", 1, 1'b0);
    prog_busy = 1'b1; addr = '0; last_byte = 8'h80;
    do_read("R9 busy over id", 1, 1'b0);
    prog_busy = 1'b0; id_sel = 1'b0;

    for (int k = 0; k < 300; k++) begin
      int unsigned r;
      r = $urandom;
      @(negedge clk);
      array_q = 8'($urandom);
      last_byte = 8'($urandom);
      addr = (r[2:0] == 3'd0) ? AW'(r[3]) : AW'($urandom);
      id_sel = r[4];
      prog_busy = r[6:5] == 2'd1;
      erase_busy = r[6:5] == 2'd2;
      do_read("R2 R3 R4 R7 R8 R10 random", 1 + int'(r[9:8]), r[10]);
    end
    b6a = prev_b6;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule